// File: doc/BRIEF.md
# Unified-View Split Register File

This block holds one set of 32 architectural registers but keeps their contents in three physical files of different widths. The integer file is 32 bits wide, the floating-point file 64 bits and the vector file 512 bits. A write names a class (integer, floating point or vector), a register index and data. Only the part of the data that the class needs is stored, in that class's file. A small per-register tag records which file holds the newest value of each register.

Every read is widened on the fly, so the register set looks like 32 registers of 512 bits each. Widening happens only on the read side, when a narrow stored value is turned into a wider view. An integer value appears sign-extended to 64 bits in the first element. A floating-point value fills the first 64 bits. Everything above the first 64-bit element reads as zero unless the value came from the vector file. A read may also ask for a narrower view: an integer view or a floating-point view. That view is cut from the low bits of the unified value.

Top module: `urf_top`

## Requirements
- R1: An integer-class write (wr_class = 2'b00) stores wr_data[31:0]. The full view (rd_class = 2'b10) of that register then returns that value sign-extended to 64 bits in bits [63:0], with bits [511:64] zero.
- R2: A floating-point-class write (wr_class = 2'b01) stores wr_data[63:0]. The full view then returns those 64 bits in bits [63:0], with bits [511:64] zero.
- R3: A vector-class write (wr_class = 2'b10) stores all 512 bits of wr_data, and the full view returns them unchanged.
- R4: A write updates the register's location tag to its class in the same clock edge. rd_tag reports the tag of register rd_idx: 2'b00 integer, 2'b01 floating point, 2'b10 vector. It never reads 2'b11.
- R5: An integer-class read (rd_class = 2'b00) returns the low 32 bits of the register's unified value in bits [31:0], with all higher bits zero, whichever file holds the register.
- R6: A floating-point-class read (rd_class = 2'b01) returns the low 64 bits of the unified value, with all higher bits zero. For a vector-tagged register this is the first 64-bit element. For an integer-tagged register it is the sign-extended integer.
- R7: The newest write to a register decides its view, whatever class earlier writes used. A narrower write after a vector write makes the upper elements read as zero again.
- R8: Reads are combinational. In a cycle where a write and a read name the same index, the read returns the value from before the write, and the new value appears after the clock edge.
- R9: Synchronous active-high reset sets every tag to integer and clears every integer entry, so every register reads as zero in every view.
- R10: A write with wr_class = 2'b11 changes neither any tag nor any read value. A cycle with wr_en low changes nothing either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_class | input | 2 | Write class: 00 integer, 01 fp, 10 vector, 11 ignored |
| wr_idx | input | 5 | Architectural register written |
| wr_data | input | 512 | Write data; the class selects how many low bits are kept |
| rd_idx | input | 5 | Architectural register read |
| rd_class | input | 2 | Read view: 00 integer, 01 fp, 10 or 11 full |
| rd_data | output | 512 | Widened read data |
| rd_tag | output | 2 | Location tag of register rd_idx |

## Verification
The bench targets integers with bit 31 set. A design that zero-extends instead of sign-extending shows zeros in bits [63:32] of the full view. It rewrites a vector register with an integer and then with a floating-point value. A design that forgot to update the tag, or that let old vector bits show through, returns stale upper elements. It reads a register in the same cycle it is written, to catch a write-through read path. After a reset it reads registers whose floating-point and vector entries still hold data. A design that did not reset the tags returns those stale values instead of zero.

// File: rtl/urf_pkg.sv
package urf_pkg;

    localparam int NREG  = 32;
    localparam int INT_W = 32;
    localparam int FP_W  = 64;
    localparam int VEC_W = 512;

    typedef enum logic [1:0] {
        LOC_INT = 2'b00,
        LOC_FP  = 2'b01,
        LOC_VEC = 2'b10,
        LOC_BAD = 2'b11
    } loc_e;

    // True when a class code names a physical file.
    function automatic logic loc_valid(input logic [1:0] c);
        return (c != LOC_BAD);
    endfunction

endpackage

// File: rtl/urf_bank.sv
module urf_bank #(
    parameter int W      = 32,
    parameter int DEPTH  = 32,
    parameter bit CLEAR  = 1'b0,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] mem [DEPTH];

    generate
        if (CLEAR) begin : g_clear
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                end else if (we) begin
                    mem[widx] <= wdata;
                end
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (we) mem[widx] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem[ridx];

endmodule

// File: rtl/urf_tags.sv
module urf_tags
    import urf_pkg::*;
#(
    parameter int DEPTH  = NREG,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  loc_e             wcls,
    input  logic [IDX_W-1:0] widx,
    input  logic [IDX_W-1:0] ridx,
    output loc_e             rtag
);

    loc_e tags [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tags[i] <= LOC_INT;
        end else if (we && loc_valid(wcls)) begin
            tags[widx] <= wcls;
        end
    end

    assign rtag = tags[ridx];

endmodule

// File: rtl/urf_widen.sv
module urf_widen
    import urf_pkg::*;
#(
    parameter int IW = INT_W,
    parameter int FW = FP_W,
    parameter int VW = VEC_W
) (
    input  loc_e          tag,
    input  loc_e          view,
    input  logic [IW-1:0] int_q,
    input  logic [FW-1:0] fp_q,
    input  logic [VW-1:0] vec_q,
    output logic [VW-1:0] data
);

    logic [VW-1:0] full;

    always_comb begin
        full = '0;
        unique case (tag)
            LOC_INT: full[FW-1:0] = {{(FW-IW){int_q[IW-1]}}, int_q};
            LOC_FP:  full[FW-1:0] = fp_q;
            LOC_VEC: full         = vec_q;
            default: full         = '0;
        endcase
    end

    always_comb begin
        data = '0;
        unique case (view)
            LOC_INT: data[IW-1:0] = full[IW-1:0];
            LOC_FP:  data[FW-1:0] = full[FW-1:0];
            default: data         = full;
        endcase
    end

endmodule

// File: rtl/urf_top.sv
module urf_top
    import urf_pkg::*;
#(
    parameter int N      = NREG,
    parameter int IW     = INT_W,
    parameter int FW     = FP_W,
    parameter int VW     = VEC_W,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_class,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [1:0]       rd_class,
    output logic [VW-1:0]    rd_data,
    output logic [1:0]       rd_tag
);

    loc_e          wcls, rcls, tag_q;
    logic          we_int, we_fp, we_vec;
    logic [IW-1:0] int_q;
    logic [FW-1:0] fp_q;
    logic [VW-1:0] vec_q;

    assign wcls   = loc_e'(wr_class);
    assign rcls   = loc_e'(rd_class);
    assign we_int = wr_en && (wcls == LOC_INT);
    assign we_fp  = wr_en && (wcls == LOC_FP);
    assign we_vec = wr_en && (wcls == LOC_VEC);

    urf_tags #(.DEPTH(N)) u_tags (
        .clk(clk), .rst(rst), .we(wr_en), .wcls(wcls),
        .widx(wr_idx), .ridx(rd_idx), .rtag(tag_q)
    );

    urf_bank #(.W(IW), .DEPTH(N), .CLEAR(1'b1)) u_int (
        .clk(clk), .rst(rst), .we(we_int), .widx(wr_idx),
        .wdata(wr_data[IW-1:0]), .ridx(rd_idx), .rdata(int_q)
    );

    urf_bank #(.W(FW), .DEPTH(N), .CLEAR(1'b0)) u_fp (
        .clk(clk), .rst(rst), .we(we_fp), .widx(wr_idx),
        .wdata(wr_data[FW-1:0]), .ridx(rd_idx), .rdata(fp_q)
    );

    urf_bank #(.W(VW), .DEPTH(N), .CLEAR(1'b0)) u_vec (
        .clk(clk), .rst(rst), .we(we_vec), .widx(wr_idx),
        .wdata(wr_data), .ridx(rd_idx), .rdata(vec_q)
    );

    urf_widen #(.IW(IW), .FW(FW), .VW(VW)) u_widen (
        .tag(tag_q), .view(rcls), .int_q(int_q), .fp_q(fp_q),
        .vec_q(vec_q), .data(rd_data)
    );

    assign rd_tag = tag_q;

endmodule

// File: rtl/urf_top_chk.sv
module urf_top_chk #(
    parameter int N      = 32,
    parameter int IW     = 32,
    parameter int FW     = 64,
    parameter int VW     = 512,
    localparam int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_class,
    input logic [IDX_W-1:0] wr_idx,
    input logic [IDX_W-1:0] rd_idx,
    input logic [1:0]       rd_class,
    input logic [VW-1:0]    rd_data,
    input logic [1:0]       rd_tag
);

    // R4: tag code 2'b11 never reaches the read port
    p_tag_legal_r4: assert property (@(posedge clk) disable iff (rst)
        rd_tag != 2'b11);

    // R4: after a valid write, reading that index reports the written class
    p_write_tag_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_class != 2'b11) |=>
        ((rd_idx != $past(wr_idx)) || (rd_tag == $past(wr_class))));

    // R5: integer view leaves everything above bit 31 clear
    p_int_view_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_class == 2'b00) |-> (rd_data[VW-1:IW] == '0));

    // R6: fp view leaves everything above bit 63 clear
    p_fp_view_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_class == 2'b01) |-> (rd_data[VW-1:FW] == '0));

    // R1: full view of an integer register is sign-extended
    p_int_sext_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_class[1] && rd_tag == 2'b00) |->
        ((rd_data[FW-1:IW] == {(FW-IW){rd_data[IW-1]}}) && (rd_data[VW-1:FW] == '0)));

    // R2: full view of an fp register has zero upper elements
    p_fp_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_class[1] && rd_tag == 2'b01) |-> (rd_data[VW-1:FW] == '0));

    // R9: the cycle after reset every register reads zero
    p_reset_zero_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((rd_data == '0) && (rd_tag == 2'b00)));

endmodule

bind urf_top urf_top_chk #(.N(N), .IW(IW), .FW(FW), .VW(VW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_class(wr_class),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_class(rd_class),
    .rd_data(rd_data), .rd_tag(rd_tag)
);

// File: tb/urf_top_bench.sv
module urf_top_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [1:0]   wr_class;
    logic [4:0]   wr_idx;
    logic [511:0] wr_data;
    logic [4:0]   rd_idx;
    logic [1:0]   rd_class;
    logic [511:0] rd_data;
    logic [1:0]   rd_tag;

    int checks   = 0;
    int failures = 0;

    logic [511:0] mval [32];
    logic [1:0]   mtag [32];

    always #10 clk = ~clk;

    urf_top u_urf_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_class(wr_class),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_class(rd_class), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    // {class, index, 64-bit seed}
    localparam logic [70:0] TAB [12] = '{
        {2'b00, 5'd1,  64'h0000_0000_8000_0001},
        {2'b00, 5'd2,  64'hFFFF_FFFF_1234_5678},
        {2'b01, 5'd3,  64'hC000_0000_DEAD_BEEF},
        {2'b10, 5'd4,  64'h0123_4567_89AB_CDEF},
        {2'b00, 5'd31, 64'h0000_0000_FFFF_FFFF},
        {2'b01, 5'd0,  64'h8000_0000_0000_0000},
        {2'b10, 5'd5,  64'hF0F0_0F0F_A5A5_5A5A},
        {2'b00, 5'd4,  64'h1111_2222_8765_4321},
        {2'b01, 5'd5,  64'h7FF8_0000_0000_0001},
        {2'b10, 5'd1,  64'hFFFF_FFFF_FFFF_FFFF},
        {2'b00, 5'd1,  64'h0000_0000_7FFF_FFFF},
        {2'b10, 5'd31, 64'h0000_0000_0000_0000}
    };

    function automatic logic [511:0] spread(input logic [63:0] s);
        logic [511:0] d;
        for (int k = 0; k < 8; k++) d[64*k +: 64] = s + 64'(k) * 64'h1111_1111_1111_1111;
        return d;
    endfunction

    function automatic logic [511:0] unified(input logic [1:0] c, input logic [511:0] d);
        logic [511:0] u = '0;
        if (c == 2'b00) u[63:0] = {{32{d[31]}}, d[31:0]};
        else if (c == 2'b01) u[63:0] = d[63:0];
        else u = d;
        return u;
    endfunction

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin
            mval[i] = '0;
            mtag[i] = 2'b00;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic do_write(input logic [1:0] c, input logic [4:0] i, input logic [511:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_class = c; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (c != 2'b11) begin
            mval[i] = unified(c, d);
            mtag[i] = c;
        end
    endtask

    task automatic read_all(input string req, input logic [4:0] i);
        rd_idx = i;
        rd_class = 2'b10; #1;
        check(req, rd_data, mval[i]);
        check({req, " tag R4"}, {510'd0, rd_tag}, {510'd0, mtag[i]});
        rd_class = 2'b00; #1;
        check({req, " int-view R5"}, rd_data, {480'd0, mval[i][31:0]});
        rd_class = 2'b01; #1;
        check({req, " fp-view R6"}, rd_data, {448'd0, mval[i][63:0]});
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_class = 2'b00; wr_idx = '0;
        wr_data = '0; rd_idx = '0; rd_class = 2'b10;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();

        // R9: reset state
        for (int i = 0; i < 32; i += 5) read_all("R9 reset", 5'(i));

        // Table walk: R1 R2 R3 R7
        for (int t = 0; t < 12; t++) begin
            do_write(TAB[t][70:69], TAB[t][68:64], spread(TAB[t][63:0]));
            case (TAB[t][70:69])
                2'b00:   read_all("R1 int write", TAB[t][68:64]);
                2'b01:   read_all("R2 fp write", TAB[t][68:64]);
                default: read_all("R3 vec write", TAB[t][68:64]);
            endcase
        end

        // R7: vector then integer then fp on the same register
        do_write(2'b10, 5'd9, spread(64'hAAAA_5555_CCCC_3333));
        read_all("R7 vec", 5'd9);
        do_write(2'b00, 5'd9, spread(64'h0000_0000_9000_0000));
        read_all("R7 int over vec", 5'd9);
        do_write(2'b01, 5'd9, spread(64'h1234_0000_0000_4321));
        read_all("R7 fp over int", 5'd9);

        // R10: class 11 write ignored
        do_write(2'b11, 5'd9, spread(64'hFFFF_0000_FFFF_0000));
        read_all("R10 class11", 5'd9);
        // R10: wr_en low ignored
        @(negedge clk);
        wr_class = 2'b10; wr_idx = 5'd9; wr_data = spread(64'h5);
        @(negedge clk);
        read_all("R10 wr_en low", 5'd9);

        // R8: read and write of the same index in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_class = 2'b00; wr_idx = 5'd9; wr_data = spread(64'h8888_8888);
        rd_idx = 5'd9; rd_class = 2'b10; #1;
        check("R8 old value", rd_data, mval[9]);
        @(posedge clk); #1;
        mval[9] = unified(2'b00, spread(64'h8888_8888));
        mtag[9] = 2'b00;
        check("R8 new value", rd_data, mval[9]);
        @(negedge clk);
        wr_en = 1'b0;

        // R9: reset after fp and vector data exist
        do_reset();
        read_all("R9 reset fp reg", 5'd0);
        read_all("R9 reset vec reg", 5'd31);
        read_all("R9 reset mixed reg", 5'd5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule